// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs the external memory bus of a small microcontroller core. The core raises a request with an address, write data, a write flag and a code-fetch flag. The sequencer then runs one bus cycle on two 8-bit ports. Each port has an output value, an output enable and an input. The cycle uses an address-latch strobe and three active-low strobes: read, write and program-fetch. When the cycle ends, the block returns the read byte together with a one-clock completion pulse. One clock of the block is one oscillator period.

The cycle timing and the port mapping come from a configuration byte that is latched after reset. This byte sets three things:
- the number of wait clocks added to the strobe,
- whether the latch strobe is short or long,
- whether the data bytes travel on the high port (page mode) or on the low port (non-page mode).

A reset loader chooses where the byte comes from. It takes either the on-chip nonvolatile byte, which arrives as an input, or an external program fetch at the fixed configuration address. Until the loader finishes, the all-ones default applies.

Top module: `xmem_seq`

## Requirements
- R1: While reset is asserted, and until a bus cycle starts, ALE is low, all three strobes are high, both port enables are low and done is low. The external configuration fetch runs with the all-ones default: zero wait clocks, a one-clock ALE and non-page mapping.
- R2: The configuration byte is taken from the on-chip input when its bit 7 is 0, whatever the value of ea_ni. It is also taken from the on-chip input when bit 7 is 1 and ea_ni is 1. When bit 7 is 1 and ea_ni is 0, the block runs a PSEN# fetch at address 16'hFFF8 and latches the byte read from the data port. An on-chip load starts no bus cycle.
- R3: Bits 6:5 of the configuration byte are an active-low wait code. Code 00 adds 3 wait clocks to the strobe, code 01 adds 2, code 10 adds 1 and code 11 adds none. The strobe is low for 1 + wait clocks.
- R4: When bit 4 of the configuration byte is 1, ALE is high for 1 clock. When bit 4 is 0, ALE is high for 3 clocks and the strobe gains one more clock. ALE is high in the first clocks of a cycle, with the address on both ports.
- R5: When bit 1 of the configuration byte is 0 (page mode), the high port carries A15:8 while ALE is high and then carries the data byte. The low port carries A7:0 for the whole cycle. Read data is taken from the high port.
- R6: When bit 1 of the configuration byte is 1 (non-page mode), the high port carries A15:8 for the whole cycle. The low port carries A7:0 while ALE is high and then carries the data byte. Read data is taken from the low port.
- R7: A write pulses WR#. A read with code_i=1 pulses PSEN#. A read with code_i=0 pulses RD#. No strobe is low while ALE is high, and at most one strobe is low at any time.
- R8: Read data is sampled from the data port at the end of the last clock of the strobe. It is presented on rdata_o no later than the done pulse.
- R9: On a write, the data port drives the write byte from the first strobe clock until one clock after WR# rises. After that, the data port is released.
- R10: A request is accepted only when the block is idle and not pulsing done. The address, data and flags are captured when the request is accepted, so later changes to them have no effect. Done is high for exactly one clock, starting A+S+1 clocks after the accepting edge, where A is the ALE length and S is the strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one oscillator period |
| rst_ni | input | 1 | Active-low synchronous reset |
| ea_ni | input | 1 | External-access select, sampled by the loader |
| cfg_rom_i | input | 8 | On-chip configuration byte |
| req_i | input | 1 | Core request, held until done |
| addr_i | input | 16 | Request address |
| wdata_i | input | 8 | Write byte |
| we_i | input | 1 | 1 = write |
| code_i | input | 1 | 1 = program fetch (reads only) |
| rdata_o | output | 8 | Read byte |
| done_o | output | 1 | One-clock completion pulse |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| psen_no | output | 1 | Program fetch strobe, active low |
| p_hi_o | output | 8 | High port output value |
| p_hi_oe_o | output | 1 | High port output enable |
| p_hi_i | input | 8 | High port input value |
| p_lo_o | output | 8 | Low port output value |
| p_lo_oe_o | output | 1 | Low port output enable |
| p_lo_i | input | 8 | Low port input value |

## Verification
Every check is tied to a cycle index k, counted from the clock edge that accepts the request. ALE is due in clocks 0 to A-1 and the strobe in clocks A to A+S-1. The write hold clock is A+S, and done and the read byte are due in clock A+S+1. The bench computes A and S from the configuration byte and samples at each falling edge against those windows. It drives the valid read byte only during clock A+S-1 and a different value in every other clock, so sampling at the wrong edge shows up as wrong data. The external configuration fetch is located by polling for the first ALE and then checked with the default windows.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int CFG_W     = 8;
    localparam int WS_W      = 2;
    localparam int CNT_W     = 3;
    localparam int SEL_BIT   = 7;
    localparam int WS_HI_BIT = 6;
    localparam int WS_LO_BIT = 5;
    localparam int ALE_BIT   = 4;
    localparam int PAGE_BIT  = 1;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_STRB,
        BUS_HOLD
    } bus_st_e;

    typedef enum logic [1:0] {
        LD_PICK,
        LD_WAIT,
        LD_DONE
    } ld_st_e;

    typedef struct packed {
        logic [WS_W-1:0] waits;
        logic            ale_long;
        logic            page_mode;
    } bus_cfg_t;

    typedef struct packed {
        ld_st_e           st;
        logic [CFG_W-1:0] cfg_byte;
    } ld_s_t;

endpackage

// File: rtl/xmem_cfg_load.sv
module xmem_cfg_load
    import xmem_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ea_ni,
    input  logic [CFG_W-1:0] rom_i,
    input  logic             bus_done_i,
    input  logic [CFG_W-1:0] bus_rdata_i,
    output logic             ld_req_o,
    output logic             ready_o,
    output bus_cfg_t         cfg_o
);

    ld_s_t ld_d, ld_q;
    logic  cfg_unused;

    always_comb begin
        ld_d = ld_q;
        case (ld_q.st)
            LD_PICK: begin
                if (!rom_i[SEL_BIT] || ea_ni) begin
                    ld_d.cfg_byte = rom_i;
                    ld_d.st       = LD_DONE;
                end else begin
                    ld_d.st = LD_WAIT;
                end
            end
            LD_WAIT: begin
                if (bus_done_i) begin
                    ld_d.cfg_byte = bus_rdata_i;
                    ld_d.st       = LD_DONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ld_q.st       <= LD_PICK;
            ld_q.cfg_byte <= '1;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign ld_req_o        = (ld_q.st == LD_WAIT);
    assign ready_o         = (ld_q.st == LD_DONE);
    assign cfg_o.waits     = ~ld_q.cfg_byte[WS_HI_BIT:WS_LO_BIT];
    assign cfg_o.ale_long  = ~ld_q.cfg_byte[ALE_BIT];
    assign cfg_o.page_mode = ~ld_q.cfg_byte[PAGE_BIT];
    assign cfg_unused      = ^{ld_q.cfg_byte[SEL_BIT], ld_q.cfg_byte[3:2], ld_q.cfg_byte[0]};

endmodule

// File: rtl/xmem_bus_fsm.sv
module xmem_bus_fsm
    import xmem_pkg::*;
#(
    parameter int PW = 8,
    localparam int AW = 2 * PW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] wdata_i,
    input  logic          we_i,
    input  logic          code_i,
    input  bus_cfg_t      cfg_i,
    input  logic [PW-1:0] hi_i,
    input  logic [PW-1:0] lo_i,
    output bus_st_e       st_o,
    output logic [AW-1:0] addr_o,
    output logic [PW-1:0] wdata_o,
    output logic          we_o,
    output logic          code_o,
    output logic [PW-1:0] rdata_o,
    output logic          done_o
);

    typedef struct packed {
        bus_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic [PW-1:0]    wdata;
        logic             we;
        logic             code;
        logic [PW-1:0]    rdata;
        logic             done;
    } bus_s_t;

    bus_s_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            BUS_IDLE: begin
                if (req_i && !s_q.done) begin
                    s_d.st    = BUS_ADDR;
                    s_d.addr  = addr_i;
                    s_d.wdata = wdata_i;
                    s_d.we    = we_i;
                    s_d.code  = code_i & ~we_i;
                    s_d.cnt   = cfg_i.ale_long ? CNT_W'(2) : '0;
                end
            end
            BUS_ADDR: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = BUS_STRB;
                    s_d.cnt = CNT_W'(cfg_i.waits) + CNT_W'(cfg_i.ale_long);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            BUS_STRB: begin
                if (s_q.cnt == '0) begin
                    s_d.st = BUS_HOLD;
                    if (!s_q.we) begin
                        s_d.rdata = cfg_i.page_mode ? hi_i : lo_i;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                s_d.st   = BUS_IDLE;
                s_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.st    <= BUS_IDLE;
            s_q.cnt   <= '0;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.we    <= 1'b0;
            s_q.code  <= 1'b0;
            s_q.rdata <= '0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o    = s_q.st;
    assign addr_o  = s_q.addr;
    assign wdata_o = s_q.wdata;
    assign we_o    = s_q.we;
    assign code_o  = s_q.code;
    assign rdata_o = s_q.rdata;
    assign done_o  = s_q.done;

endmodule

// File: rtl/xmem_port_map.sv
module xmem_port_map
    import xmem_pkg::*;
#(
    parameter int PW = 8,
    localparam int AW = 2 * PW
) (
    input  bus_st_e       st_i,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] wdata_i,
    input  logic          we_i,
    input  logic          code_i,
    input  logic          page_mode_i,
    output logic          ale_o,
    output logic          rd_no,
    output logic          wr_no,
    output logic          psen_no,
    output logic [PW-1:0] hi_o,
    output logic          hi_oe_o,
    output logic [PW-1:0] lo_o,
    output logic          lo_oe_o
);

    logic          strobe;
    logic          data_phase;
    logic [PW-1:0] a_hi;
    logic [PW-1:0] a_lo;

    assign strobe     = (st_i == BUS_STRB);
    assign data_phase = (st_i == BUS_STRB) || (st_i == BUS_HOLD);
    assign a_hi       = addr_i[AW-1:PW];
    assign a_lo       = addr_i[PW-1:0];

    assign ale_o   = (st_i == BUS_ADDR);
    assign wr_no   = ~(strobe & we_i);
    assign rd_no   = ~(strobe & ~we_i & ~code_i);
    assign psen_no = ~(strobe & ~we_i & code_i);

    always_comb begin
        hi_o    = '0;
        hi_oe_o = 1'b0;
        lo_o    = '0;
        lo_oe_o = 1'b0;
        if (st_i == BUS_ADDR) begin
            hi_o    = a_hi;
            hi_oe_o = 1'b1;
            lo_o    = a_lo;
            lo_oe_o = 1'b1;
        end else if (data_phase) begin
            if (page_mode_i) begin
                hi_o    = we_i ? wdata_i : '0;
                hi_oe_o = we_i;
                lo_o    = a_lo;
                lo_oe_o = 1'b1;
            end else begin
                hi_o    = a_hi;
                hi_oe_o = 1'b1;
                lo_o    = we_i ? wdata_i : '0;
                lo_oe_o = we_i;
            end
        end
    end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int          PW         = 8,
    parameter logic [15:0] FETCH_ADDR = 16'hFFF8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ea_ni,
    input  logic [CFG_W-1:0] cfg_rom_i,
    input  logic             req_i,
    input  logic [2*PW-1:0]  addr_i,
    input  logic [PW-1:0]    wdata_i,
    input  logic             we_i,
    input  logic             code_i,
    output logic [PW-1:0]    rdata_o,
    output logic             done_o,
    output logic             ale_o,
    output logic             rd_no,
    output logic             wr_no,
    output logic             psen_no,
    output logic [PW-1:0]    p_hi_o,
    output logic             p_hi_oe_o,
    input  logic [PW-1:0]    p_hi_i,
    output logic [PW-1:0]    p_lo_o,
    output logic             p_lo_oe_o,
    input  logic [PW-1:0]    p_lo_i
);

    localparam int AW = 2 * PW;

    bus_cfg_t      bus_cfg;
    logic          ld_req;
    logic          ld_ready;
    logic          cfg_page;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic          bus_code;
    logic          bus_done;
    logic [PW-1:0] bus_rdata;
    bus_st_e       bus_st;
    logic [AW-1:0] cyc_addr;
    logic [PW-1:0] cyc_wdata;
    logic          cyc_we;
    logic          cyc_code;

    assign bus_req  = ld_ready ? req_i : ld_req;
    assign bus_addr = ld_ready ? addr_i : AW'(FETCH_ADDR);
    assign bus_we   = ld_ready & we_i;
    assign bus_code = ld_ready ? code_i : 1'b1;
    assign done_o   = bus_done & ld_ready;
    assign rdata_o  = bus_rdata;
    assign cfg_page = bus_cfg.page_mode;

    xmem_cfg_load u_load (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ea_ni       (ea_ni),
        .rom_i       (cfg_rom_i),
        .bus_done_i  (bus_done),
        .bus_rdata_i (bus_rdata[CFG_W-1:0]),
        .ld_req_o    (ld_req),
        .ready_o     (ld_ready),
        .cfg_o       (bus_cfg)
    );

    xmem_bus_fsm #(.PW(PW)) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (bus_req),
        .addr_i  (bus_addr),
        .wdata_i (wdata_i),
        .we_i    (bus_we),
        .code_i  (bus_code),
        .cfg_i   (bus_cfg),
        .hi_i    (p_hi_i),
        .lo_i    (p_lo_i),
        .st_o    (bus_st),
        .addr_o  (cyc_addr),
        .wdata_o (cyc_wdata),
        .we_o    (cyc_we),
        .code_o  (cyc_code),
        .rdata_o (bus_rdata),
        .done_o  (bus_done)
    );

    xmem_port_map #(.PW(PW)) u_map (
        .st_i        (bus_st),
        .addr_i      (cyc_addr),
        .wdata_i     (cyc_wdata),
        .we_i        (cyc_we),
        .code_i      (cyc_code),
        .page_mode_i (bus_cfg.page_mode),
        .ale_o       (ale_o),
        .rd_no       (rd_no),
        .wr_no       (wr_no),
        .psen_no     (psen_no),
        .hi_o        (p_hi_o),
        .hi_oe_o     (p_hi_oe_o),
        .lo_o        (p_lo_o),
        .lo_oe_o     (p_lo_oe_o)
    );

endmodule

// File: rtl/xmem_seq_chk.sv
module xmem_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic ale_o,
    input logic rd_no,
    input logic wr_no,
    input logic psen_no,
    input logic done_o,
    input logic p_hi_oe_o,
    input logic p_lo_oe_o,
    input logic cfg_page
);

    logic [2:0] ale_run;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ale_run <= '0;
        end else if (ale_o) begin
            ale_run <= (ale_run == 3'd7) ? ale_run : ale_run + 3'd1;
        end else begin
            ale_run <= '0;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({~rd_no, ~wr_no, ~psen_no}) <= 1); // R7
    AST_ALE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_o |-> (rd_no && wr_no && psen_no)); // R7
    AST_DONE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10
    AST_WR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_no |-> (cfg_page ? p_hi_oe_o : p_lo_oe_o)); // R9
    AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_no) |-> (cfg_page ? p_hi_oe_o : p_lo_oe_o)); // R9
    AST_PAGE_ADDR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_page && !(rd_no && wr_no && psen_no)) |-> p_lo_oe_o); // R5
    AST_PAGE_READ_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_page && !(rd_no && psen_no)) |-> !p_hi_oe_o); // R5
    AST_NONPAGE_ADDR_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_page && !(rd_no && wr_no && psen_no)) |-> p_hi_oe_o); // R6
    AST_NONPAGE_READ_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_page && !(rd_no && psen_no)) |-> !p_lo_oe_o); // R6
    AST_ALE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_run <= 3'd3); // R4

endmodule

bind xmem_seq xmem_seq_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ale_o     (ale_o),
    .rd_no     (rd_no),
    .wr_no     (wr_no),
    .psen_no   (psen_no),
    .done_o    (done_o),
    .p_hi_oe_o (p_hi_oe_o),
    .p_lo_oe_o (p_lo_oe_o),
    .cfg_page  (cfg_page)
);

// File: tb/sim_xmem_seq.sv
`timescale 1ns/1ps
module sim_xmem_seq;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        ea_ni = 1'b1;
    logic [7:0]  cfg_rom_i = 8'hFF;
    logic        req_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        we_i = 1'b0;
    logic        code_i = 1'b0;
    logic [7:0]  rdata_o;
    logic        done_o;
    logic        ale_o;
    logic        rd_no;
    logic        wr_no;
    logic        psen_no;
    logic [7:0]  p_hi_o;
    logic        p_hi_oe_o;
    logic [7:0]  p_hi_i = '0;
    logic [7:0]  p_lo_o;
    logic        p_lo_oe_o;
    logic [7:0]  p_lo_i = '0;

    int total = 0;
    int bad = 0;
    int k_g = 0;

    always #2 clk = ~clk;

    xmem_seq u0 (
        .clk_i(clk), .rst_ni(rst_ni), .ea_ni(ea_ni), .cfg_rom_i(cfg_rom_i),
        .req_i(req_i), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
        .code_i(code_i), .rdata_o(rdata_o), .done_o(done_o), .ale_o(ale_o),
        .rd_no(rd_no), .wr_no(wr_no), .psen_no(psen_no),
        .p_hi_o(p_hi_o), .p_hi_oe_o(p_hi_oe_o), .p_hi_i(p_hi_i),
        .p_lo_o(p_lo_o), .p_lo_oe_o(p_lo_oe_o), .p_lo_i(p_lo_i)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, k_g, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] rom, input logic ea);
        @(negedge clk);
        rst_ni = 1'b0;
        cfg_rom_i = rom;
        ea_ni = ea;
        req_i = 1'b0;
        repeat (3) @(negedge clk);
        k_g = -1;
        chk("R1 reset ale", ale_o, 0);
        chk("R1 reset strobes", {rd_no, wr_no, psen_no}, 3'b111);
        chk("R1 reset port enables", {p_hi_oe_o, p_lo_oe_o}, 2'b00);
        chk("R1 reset done", done_o, 0);
        rst_ni = 1'b1;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            k_g = -2;
            chk("R2 no bus cycle for on-chip load", ale_o, 0);
        end
    endtask

    task automatic bus_cycle(input bit via_req, input bit we, input bit code,
                             input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] rd, input int na, input int ns,
                             input bit page);
        if (via_req) begin
            addr_i = a; wdata_i = wd; we_i = we; code_i = code; req_i = 1'b1;
            @(negedge clk);
        end else begin
            for (int n = 0; n < 20 && !ale_o; n++) @(negedge clk);
        end
        for (int k = 0; k <= na + ns + 2; k++) begin
            bit in_a, in_s, in_h, in_d, hoe, loe;
            logic [7:0] hv, lv;
            k_g = k;
            in_a = (k < na);
            in_s = (k >= na) && (k < na + ns);
            in_h = (k == na + ns);
            in_d = (k == na + ns + 1);
            if (page) begin
                p_hi_i = (k == na + ns - 1) ? rd : ~rd;
                p_lo_i = rd ^ 8'h3C;
            end else begin
                p_lo_i = (k == na + ns - 1) ? rd : ~rd;
                p_hi_i = rd ^ 8'h3C;
            end
            if (k == 1 && via_req) begin
                addr_i = ~a; wdata_i = ~wd; we_i = ~we; code_i = ~code;
            end
            chk("R4 ale window", ale_o, in_a);
            chk("R7 R3 rd strobe", rd_no, !(in_s && !we && !code));
            chk("R7 R3 psen strobe", psen_no, !(in_s && !we && code));
            chk("R7 R3 wr strobe", wr_no, !(in_s && we));
            chk("R10 done pulse", done_o, in_d && via_req);
            hoe = in_a ? 1'b1 : (in_s || in_h) ? (page ? we : 1'b1) : 1'b0;
            loe = in_a ? 1'b1 : (in_s || in_h) ? (page ? 1'b1 : we) : 1'b0;
            hv  = (in_a || !page) ? a[15:8] : wd;
            lv  = (in_a || page) ? a[7:0] : wd;
            chk(page ? "R5 R9 high enable" : "R6 high enable", p_hi_oe_o, hoe);
            chk(page ? "R5 low enable" : "R6 R9 low enable", p_lo_oe_o, loe);
            if (hoe) chk(page ? "R5 R9 high value" : "R6 high value", p_hi_o, hv);
            if (loe) chk(page ? "R5 low value" : "R6 R9 low value", p_lo_o, lv);
            if (in_d && via_req && !we) chk("R8 read byte", rdata_o, rd);
            if (in_d) req_i = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R3 R4 R5 R6: sweep every wait code, ALE length and port mapping
        for (int idx = 0; idx < 16; idx++) begin
            logic [1:0]  wc;
            logic        al, pg;
            logic [7:0]  rom;
            logic [15:0] a;
            int na, ns;
            wc  = idx[3:2];
            al  = idx[1];
            pg  = idx[0];
            rom = {1'b0, wc, al, 2'b11, pg, 1'b1};
            na  = al ? 1 : 3;
            ns  = 1 + (3 - int'(wc)) + (al ? 0 : 1);
            a   = 16'h1234 + 16'(idx * 16'h0F1F);
            do_reset(rom, al ^ pg);
            quiet(4);
            bus_cycle(1, 0, 0, a, 8'h00, 8'(idx * 53 + 9), na, ns, !pg);
            bus_cycle(1, 1, 0, ~a, 8'(idx * 37 + 5), 8'h00, na, ns, !pg);
            bus_cycle(1, 0, 1, a ^ 16'h5AA5, 8'h00, 8'(idx * 71 + 2), na, ns, !pg);
        end

        // R2: selector set with ea_ni high keeps the on-chip byte
        do_reset(8'hBD, 1'b1);
        quiet(5);
        bus_cycle(1, 0, 0, 16'hC3A1, 8'h00, 8'h96, 1, 3, 1);
        bus_cycle(1, 1, 0, 16'h0F0F, 8'hE7, 8'h00, 1, 3, 1);

        // R2 R1: selector set with ea_ni low fetches externally at default timing
        do_reset(8'hFF, 1'b0);
        bus_cycle(0, 0, 1, 16'hFFF8, 8'h00, 8'h0D, 1, 1, 0);
        bus_cycle(1, 0, 0, 16'h4321, 8'h00, 8'hA5, 3, 5, 1);
        bus_cycle(1, 1, 0, 16'h8001, 8'h3C, 8'h00, 3, 5, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule